// File: doc/BRIEF.md
# Flash Sector Erase and Byte Program Sequencer

This block runs one erase or program operation on a byte-wide parallel NOR flash that uses the common two-cycle unlock command set. A request names the operation, a byte offset and, for programming, a byte count. For an erase it issues the unlock and sector-erase command writes and then polls the device. For a program it takes one byte at a time from a valid/ready stream, sends the program command writes for that byte and polls until the byte has been written.

Erase completion is found by comparing consecutive status reads: once the toggle flag (status bit 6) stops changing, the erase is complete. Program completion is found when status bit 7 shows the true value of bit 7 of the written byte. If the device raises its own timeout flag (status bit 5), the block takes confirmation reads. A programmable limit on the number of status reads catches a device that never finishes. A successful operation ends with a reset command that puts the device back in read mode. A failed operation ends at once, with an error code.

Top module: `flash_seq`

## Requirements
- R1: An erase issues exactly these bus writes, in this order: 0xF0 at address 0, 0xAA at 0xAAA, 0x55 at 0x554, 0x80 at 0xAAA, 0xAA at 0xAAA, 0x55 at 0x554, and then 0x30 at the unshifted `base_off`. The command addresses are the word offsets 0x555 and 0x2AA shifted left by `CMD_SHIFT` (default 1).
- R2: A program of N bytes accepts byte i from the stream (`wr_valid` && `wr_ready`). For that byte it writes 0xF0 at 0, 0xAA at 0xAAA, 0x55 at 0x554 and 0xA0 at 0xAAA, then the byte itself at `base_off`+i. `wr_ready` is high only while the block waits for a byte, and no bus cycle occurs in that time.
- R3: During an erase, after one reference read, each status read is compared with the previous read. If bit 6 is unchanged, the erase has succeeded.
- R4: During an erase, a read where bit 6 changed and bit 5 is set is followed by two more reads. If bit 6 differs between these two reads, the operation ends with error 2. Otherwise the erase has succeeded. When bit 5 is set, the confirmation reads are taken before the read limit is applied.
- R5: During a program, a byte is complete when status bit 7 equals bit 7 of the written byte.
- R6: During a program, a read with bit 7 wrong and bit 5 set is followed by one reread. A matching bit 7 completes the byte; otherwise the operation ends with error 2.
- R7: If `erase_limit` (for an erase) or `write_limit` (for a program) polling reads fail to show completion, the operation ends with error 1 on the last of those reads. A limit of 0 acts as 1. The count starts again for every programmed byte.
- R8: A successful operation ends with one write of 0xF0 at address 0 and then `done` with `err` = 0. A failed operation issues no further bus cycle before `done`.
- R9: A program with length 0 issues only the final 0xF0 write and completes with `err` = 0.
- R10: `busy` rises the cycle after an accepted `start`. `done` is a single-cycle pulse during which `busy` is still high, and `busy` is low in the next cycle. A `start` while busy is ignored.
- R11: After reset, `busy`, `done`, `wr_ready`, `fl_we` and `fl_re` are low.
- R12: `fl_we` and `fl_re` are never high in the same cycle, and each bus cycle lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| op | input | 1 | 0 = sector erase, 1 = byte program |
| base_off | input | AW | Sector offset or first byte offset |
| length | input | LW | Number of bytes to program |
| erase_limit | input | TW | Maximum polling reads for an erase |
| write_limit | input | TW | Maximum polling reads per programmed byte |
| wr_data | input | 8 | Program data stream byte |
| wr_valid | input | 1 | Stream byte available |
| wr_ready | output | 1 | Block accepts a stream byte |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write cycle |
| fl_re | output | 1 | Flash read cycle, data captured at the clock edge |
| fl_rdata | input | 8 | Flash read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| err | output | 2 | Result: 0 ok, 1 read-limit timeout, 2 device timeout |

## Verification
The device timeout flag and the expiry of the read limit can both fall on the same status read. The bench provokes this with an erase whose read limit is 2. The second polling read still shows bit 6 changing and also carries bit 5. The confirmation reads that follow are stable, so the correct result is a successful erase after five reads that ends with the reset write. A design that applies the limit first would instead report error 1 after three reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_PROG  = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_CYCLE  = 2'd1,
        ERR_DEVICE = 2'd2
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT,
        S_CMD,
        S_EREF,
        S_EPOLL,
        S_ECHK1,
        S_ECHK2,
        S_PPOLL,
        S_PCHK,
        S_EXIT,
        S_DONE
    } state_e;

    typedef struct packed {
        logic [11:0] word_addr;
        logic [7:0]  value;
        logic        at_target;
        logic        use_data;
        logic        final_step;
    } cmd_t;

    localparam logic [7:0]  CMD_RESET   = 8'hF0;
    localparam logic [7:0]  UNLOCK_1    = 8'hAA;
    localparam logic [7:0]  UNLOCK_2    = 8'h55;
    localparam logic [7:0]  CMD_ESETUP  = 8'h80;
    localparam logic [7:0]  CMD_SECTOR  = 8'h30;
    localparam logic [7:0]  CMD_PROGRAM = 8'hA0;
    localparam logic [11:0] WADDR_1     = 12'h555;
    localparam logic [11:0] WADDR_2     = 12'h2AA;

    localparam logic [7:0]  MASK_TOGGLE = 8'h40;
    localparam logic [7:0]  MASK_DPOLL  = 8'h80;
    localparam logic [7:0]  MASK_DEVTO  = 8'h20;

    function automatic cmd_t mk_cmd(logic [11:0] a, logic [7:0] v,
                                    logic tgt, logic dat, logic fin);
        cmd_t c;
        c.word_addr  = a;
        c.value      = v;
        c.at_target  = tgt;
        c.use_data   = dat;
        c.final_step = fin;
        return c;
    endfunction

    // Command step table for both operations.
    function automatic cmd_t seq_step(op_e op, logic [2:0] idx);
        cmd_t c;
        case (idx)
            3'd0: c = mk_cmd(12'h000, CMD_RESET, 1'b0, 1'b0, 1'b0);
            3'd1: c = mk_cmd(WADDR_1, UNLOCK_1, 1'b0, 1'b0, 1'b0);
            3'd2: c = mk_cmd(WADDR_2, UNLOCK_2, 1'b0, 1'b0, 1'b0);
            3'd3: c = (op == OP_ERASE) ? mk_cmd(WADDR_1, CMD_ESETUP,  1'b0, 1'b0, 1'b0)
                                       : mk_cmd(WADDR_1, CMD_PROGRAM, 1'b0, 1'b0, 1'b0);
            3'd4: c = (op == OP_ERASE) ? mk_cmd(WADDR_1, UNLOCK_1, 1'b0, 1'b0, 1'b0)
                                       : mk_cmd(12'h000, 8'h00, 1'b1, 1'b1, 1'b1);
            3'd5: c = mk_cmd(WADDR_2, UNLOCK_2, 1'b0, 1'b0, 1'b0);
            3'd6: c = mk_cmd(12'h000, CMD_SECTOR, 1'b1, 1'b0, 1'b1);
            default: c = mk_cmd(12'h000, CMD_RESET, 1'b0, 1'b0, 1'b1);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flash_cmd_gen.sv
module flash_cmd_gen
    import flash_seq_pkg::*;
#(
    parameter int AW        = 24,
    parameter int CMD_SHIFT = 1
) (
    input  op_e           op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] target,
    input  logic [7:0]    payload,
    output logic [AW-1:0] addr,
    output logic [7:0]    wdata,
    output logic          final_step
);
    cmd_t          c;
    logic [AW-1:0] cmd_addr;

    assign c = seq_step(op, step);

    generate
        if (CMD_SHIFT == 0) begin : g_noshift
            assign cmd_addr = AW'(c.word_addr);
        end else begin : g_shift
            assign cmd_addr = AW'(c.word_addr) << CMD_SHIFT;
        end
    endgenerate

    assign addr       = c.at_target ? target  : cmd_addr;
    assign wdata      = c.use_data  ? payload : c.value;
    assign final_step = c.final_step;
endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval
    import flash_seq_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] cur,
    input  logic [7:0] ref_val,
    output logic       finished,
    output logic       dev_flag
);
    logic [7:0] diff;
    logic [7:0] mask;

    assign diff     = cur ^ ref_val;
    assign mask     = (op == OP_ERASE) ? MASK_TOGGLE : MASK_DPOLL;
    assign finished = ~|(diff & mask);
    assign dev_flag = |(cur & MASK_DEVTO);
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [TW-1:0] limit,
    output logic          last
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != '1)) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign last = ({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW        = 24,
    parameter int LW        = 16,
    parameter int TW        = 32,
    parameter int CMD_SHIFT = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op,
    input  logic [AW-1:0] base_off,
    input  logic [LW-1:0] length,
    input  logic [TW-1:0] erase_limit,
    input  logic [TW-1:0] write_limit,
    input  logic [7:0]    wr_data,
    input  logic          wr_valid,
    output logic          wr_ready,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    output logic          fl_we,
    output logic          fl_re,
    input  logic [7:0]    fl_rdata,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err
);
    state_e        state_q;
    op_e           op_q;
    logic [AW-1:0] off_q;
    logic [LW-1:0] rem_q;
    logic [2:0]    step_q;
    logic [7:0]    data_q;
    logic [7:0]    prev_q;
    err_e          err_q;

    logic [2:0]    step_sel;
    logic [AW-1:0] gen_addr;
    logic [7:0]    gen_wdata;
    logic          gen_final;
    logic [7:0]    ref_val;
    logic          finished;
    logic          dev_flag;
    logic          limit_hit;
    logic          tmr_clr;
    logic          tmr_inc;
    logic [TW-1:0] limit_sel;
    logic          last_byte;

    assign step_sel = (state_q == S_EXIT) ? 3'd0 : step_q;

    flash_cmd_gen #(.AW(AW), .CMD_SHIFT(CMD_SHIFT)) u_cmd (
        .op         (op_q),
        .step       (step_sel),
        .target     (off_q),
        .payload    (data_q),
        .addr       (gen_addr),
        .wdata      (gen_wdata),
        .final_step (gen_final)
    );

    assign ref_val = (op_q == OP_ERASE) ? prev_q : data_q;

    flash_status_eval u_eval (
        .op       (op_q),
        .cur      (fl_rdata),
        .ref_val  (ref_val),
        .finished (finished),
        .dev_flag (dev_flag)
    );

    assign tmr_clr   = (state_q == S_CMD) && gen_final;
    assign tmr_inc   = (state_q == S_EPOLL) || (state_q == S_PPOLL);
    assign limit_sel = (op_q == OP_ERASE) ? erase_limit : write_limit;

    flash_poll_timer #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .limit (limit_sel),
        .last  (limit_hit)
    );

    assign last_byte = (rem_q == LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= OP_ERASE;
            off_q   <= '0;
            rem_q   <= '0;
            step_q  <= '0;
            data_q  <= '0;
            prev_q  <= '0;
            err_q   <= ERR_NONE;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        op_q   <= op_e'(op);
                        off_q  <= base_off;
                        rem_q  <= length;
                        step_q <= '0;
                        err_q  <= ERR_NONE;
                        if (op_e'(op) == OP_ERASE) begin
                            state_q <= S_CMD;
                        end else if (length == '0) begin
                            state_q <= S_EXIT;
                        end else begin
                            state_q <= S_WAIT;
                        end
                    end
                end
                S_WAIT: begin
                    if (wr_valid) begin
                        data_q  <= wr_data;
                        step_q  <= '0;
                        state_q <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (gen_final) begin
                        state_q <= (op_q == OP_ERASE) ? S_EREF : S_PPOLL;
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                S_EREF: begin
                    prev_q  <= fl_rdata;
                    state_q <= S_EPOLL;
                end
                S_EPOLL: begin
                    if (finished) begin
                        state_q <= S_EXIT;
                    end else if (dev_flag) begin
                        state_q <= S_ECHK1;
                    end else if (limit_hit) begin
                        err_q   <= ERR_CYCLE;
                        state_q <= S_DONE;
                    end else begin
                        prev_q <= fl_rdata;
                    end
                end
                S_ECHK1: begin
                    prev_q  <= fl_rdata;
                    state_q <= S_ECHK2;
                end
                S_ECHK2: begin
                    if (finished) begin
                        state_q <= S_EXIT;
                    end else begin
                        err_q   <= ERR_DEVICE;
                        state_q <= S_DONE;
                    end
                end
                S_PPOLL: begin
                    if (finished) begin
                        if (last_byte) begin
                            state_q <= S_EXIT;
                        end else begin
                            rem_q   <= rem_q - LW'(1);
                            off_q   <= off_q + AW'(1);
                            state_q <= S_WAIT;
                        end
                    end else if (dev_flag) begin
                        state_q <= S_PCHK;
                    end else if (limit_hit) begin
                        err_q   <= ERR_CYCLE;
                        state_q <= S_DONE;
                    end
                end
                S_PCHK: begin
                    if (finished) begin
                        if (last_byte) begin
                            state_q <= S_EXIT;
                        end else begin
                            rem_q   <= rem_q - LW'(1);
                            off_q   <= off_q + AW'(1);
                            state_q <= S_WAIT;
                        end
                    end else begin
                        err_q   <= ERR_DEVICE;
                        state_q <= S_DONE;
                    end
                end
                S_EXIT: begin
                    state_q <= S_DONE;
                end
                S_DONE: begin
                    state_q <= S_IDLE;
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        fl_we = (state_q == S_CMD) || (state_q == S_EXIT);
        fl_re = (state_q == S_EREF)  || (state_q == S_EPOLL) ||
                (state_q == S_ECHK1) || (state_q == S_ECHK2) ||
                (state_q == S_PPOLL) || (state_q == S_PCHK);
        if (fl_we) begin
            fl_addr  = gen_addr;
            fl_wdata = gen_wdata;
        end else if (fl_re) begin
            fl_addr  = off_q;
            fl_wdata = '0;
        end else begin
            fl_addr  = '0;
            fl_wdata = '0;
        end
    end

    assign wr_ready = (state_q == S_WAIT);
    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_DONE);
    assign err      = err_q;

    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re)); // R12
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy); // R10
    AST_EXIT_BEFORE_OK: assert property (@(posedge clk) disable iff (rst)
        (done && err == 2'(ERR_NONE)) |->
        $past(fl_we && fl_addr == '0 && fl_wdata == CMD_RESET)); // R8
    AST_NO_EXIT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (done && err != 2'(ERR_NONE)) |-> $past(fl_re)); // R8
    AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (!fl_we && !fl_re)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fl_we && !fl_re && !wr_ready)); // R11
    AST_CYCLE_ERR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (done && err == 2'(ERR_CYCLE)) |-> $past(fl_re)); // R7
endmodule

// File: tb/tb_flash_seq.sv
`timescale 1ns/1ps
module tb_flash_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        op_i;
    logic [23:0] base_off;
    logic [15:0] length;
    logic [31:0] erase_limit;
    logic [31:0] write_limit;
    logic [7:0]  wr_data;
    logic        wr_valid;
    logic        wr_ready;
    logic [23:0] fl_addr;
    logic [7:0]  fl_wdata;
    logic        fl_we;
    logic        fl_re;
    logic [7:0]  fl_rdata;
    logic        busy;
    logic        done;
    logic [1:0]  err;

    always #2.5 clk = ~clk;

    flash_seq dut (
        .clk(clk), .rst(rst), .start(start), .op(op_i), .base_off(base_off),
        .length(length), .erase_limit(erase_limit), .write_limit(write_limit),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Flash status model: scripted read sequence, last entry repeats.
    logic [7:0] seq [0:31];
    int seq_len = 1;
    int rd_cnt  = 0;
    int rd_base = 0;

    function automatic logic [7:0] stat_at(int i);
        int k;
        k = (i >= seq_len) ? seq_len - 1 : i;
        if (k < 0) k = 0;
        return seq[k];
    endfunction

    assign fl_rdata = stat_at(rd_cnt - rd_base);
    always @(posedge clk) if (fl_re) rd_cnt <= rd_cnt + 1;

    // Write log
    logic [23:0] lg_addr [0:255];
    logic [7:0]  lg_data [0:255];
    int wr_cnt = 0;
    always @(negedge clk) begin
        if (fl_we) begin
            lg_addr[wr_cnt[7:0]] <= fl_addr;
            lg_data[wr_cnt[7:0]] <= fl_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    logic [23:0] ex_addr [0:63];
    logic [7:0]  ex_data [0:63];
    int ex_n;
    logic [7:0] tx [0:7];

    int got_err, got_rd, got_wr, wr_base;
    bit stop;

    task automatic chk(input string req, input bit ok, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ex_push(input logic [23:0] a, input logic [7:0] d);
        ex_addr[ex_n] = a;
        ex_data[ex_n] = d;
        ex_n++;
    endtask

    task automatic ex_erase(input logic [23:0] off);
        ex_push(24'h0, 8'hF0); ex_push(24'hAAA, 8'hAA); ex_push(24'h554, 8'h55);
        ex_push(24'hAAA, 8'h80); ex_push(24'hAAA, 8'hAA); ex_push(24'h554, 8'h55);
        ex_push(off, 8'h30);
    endtask

    task automatic ex_prog(input logic [23:0] off, input logic [7:0] d);
        ex_push(24'h0, 8'hF0); ex_push(24'hAAA, 8'hAA); ex_push(24'h554, 8'h55);
        ex_push(24'hAAA, 8'hA0); ex_push(off, d);
    endtask

    task automatic cmp_log(input string req);
        int n;
        chk(req, got_wr == ex_n, "write count", got_wr, ex_n);
        n = (got_wr < ex_n) ? got_wr : ex_n;
        for (int i = 0; i < n; i++) begin
            logic [7:0] idx;
            idx = 8'(wr_base + i);
            chk(req, lg_addr[idx] == ex_addr[i], "write addr", int'(lg_addr[idx]), int'(ex_addr[i]));
            chk(req, lg_data[idx] == ex_data[i], "write data", int'(lg_data[idx]), int'(ex_data[i]));
        end
    endtask

    task automatic run_op(input logic op, input logic [23:0] off, input int len,
                          input int elim, input int wlim, input int gap, input bit poke);
        int wd;
        @(negedge clk);
        rd_base     = rd_cnt;
        wr_base     = wr_cnt;
        stop        = 1'b0;
        op_i        = op;
        base_off    = off;
        length      = 16'(len);
        erase_limit = 32'(elim);
        write_limit = 32'(wlim);
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
        chk("R10", busy === 1'b1, "busy after start", int'(busy), 1);
        fork
            begin
                for (int i = 0; i < len; i++) begin
                    if (stop) break;
                    repeat (gap) @(negedge clk);
                    wr_data  = tx[i];
                    wr_valid = 1'b1;
                    while (!wr_ready && !stop) @(negedge clk);
                    @(negedge clk);
                    wr_valid = 1'b0;
                end
            end
            begin
                wd = 0;
                while (done !== 1'b1 && wd < 3000) begin
                    start = poke && (wd == 3);
                    if (poke && wd == 3) op_i = ~op;
                    @(negedge clk);
                    wd++;
                end
                start = 1'b0;
                stop  = 1'b1;
            end
        join
        if (done !== 1'b1) begin
            n_chk++; n_bad++;
            $display("FAIL R10 done never seen: actual 0 expected 1");
        end
        got_err = int'(err);
        got_rd  = rd_cnt - rd_base;
        @(negedge clk);
        got_wr  = wr_cnt - wr_base;
        chk("R10", done === 1'b0 && busy === 1'b0, "done/busy after pulse",
            int'({done, busy}), 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; op_i = 1'b0; base_off = '0; length = '0;
        erase_limit = 32'd100; write_limit = 32'd100; wr_data = '0; wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", {busy, done, wr_ready, fl_we, fl_re} === 5'b0, "reset outputs",
            int'({busy, done, wr_ready, fl_we, fl_re}), 0);
    endtask

    task automatic t_erase_quick;
        seq[0] = 8'h40; seq[1] = 8'h40; seq_len = 2;
        run_op(1'b0, 24'h012000, 0, 100, 100, 0, 1'b0);
        ex_n = 0; ex_erase(24'h012000); ex_push(24'h0, 8'hF0);
        cmp_log("R1");
        chk("R3", got_err == 0, "err", got_err, 0);
        chk("R3", got_rd == 2, "reads", got_rd, 2);
    endtask

    task automatic t_erase_toggle;
        seq[0] = 8'h00; seq[1] = 8'h40; seq[2] = 8'h00; seq[3] = 8'h40; seq[4] = 8'h40;
        seq_len = 5;
        run_op(1'b0, 24'h030000, 0, 100, 100, 0, 1'b0);
        ex_n = 0; ex_erase(24'h030000); ex_push(24'h0, 8'hF0);
        cmp_log("R8");
        chk("R3", got_err == 0, "err", got_err, 0);
        chk("R3", got_rd == 5, "reads", got_rd, 5);
    endtask

    task automatic t_erase_devto;
        seq[0] = 8'h00; seq[1] = 8'h60; seq[2] = 8'h20; seq[3] = 8'h60; seq_len = 4;
        run_op(1'b0, 24'h040000, 0, 100, 100, 0, 1'b0);
        ex_n = 0; ex_erase(24'h040000);
        cmp_log("R8");
        chk("R4", got_err == 2, "err", got_err, 2);
        chk("R4", got_rd == 4, "reads", got_rd, 4);
    endtask

    task automatic t_erase_devto_clear;
        seq[0] = 8'h00; seq[1] = 8'h60; seq[2] = 8'h60; seq[3] = 8'h60; seq_len = 4;
        run_op(1'b0, 24'h050000, 0, 100, 100, 0, 1'b0);
        chk("R4", got_err == 0, "err", got_err, 0);
        chk("R4", got_rd == 4, "reads", got_rd, 4);
        chk("R8", got_wr == 8, "writes", got_wr, 8);
    endtask

    task automatic t_erase_cycto;
        for (int i = 0; i < 32; i++) seq[i] = (i % 2 == 0) ? 8'h00 : 8'h40;
        seq_len = 32;
        run_op(1'b0, 24'h060000, 0, 3, 100, 0, 1'b0);
        chk("R7", got_err == 1, "err", got_err, 1);
        chk("R7", got_rd == 4, "reads", got_rd, 4);
        chk("R8", got_wr == 7, "writes after error", got_wr, 7);
    endtask

    task automatic t_coincide;
        seq[0] = 8'h00; seq[1] = 8'h40; seq[2] = 8'h20; seq[3] = 8'h60; seq[4] = 8'h60;
        seq_len = 5;
        run_op(1'b0, 24'h070000, 0, 2, 100, 0, 1'b0);
        chk("R4", got_err == 0, "err bit5 vs limit", got_err, 0);
        chk("R4", got_rd == 5, "reads bit5 vs limit", got_rd, 5);
    endtask

    task automatic t_prog_two;
        tx[0] = 8'h80; tx[1] = 8'h12;
        seq[0] = 8'h80; seq[1] = 8'h00; seq_len = 2;
        run_op(1'b1, 24'h000100, 2, 100, 100, 0, 1'b0);
        ex_n = 0; ex_prog(24'h000100, 8'h80); ex_prog(24'h000101, 8'h12);
        ex_push(24'h0, 8'hF0);
        cmp_log("R2");
        chk("R5", got_err == 0, "err", got_err, 0);
        chk("R5", got_rd == 2, "reads", got_rd, 2);
    endtask

    task automatic t_prog_gap;
        tx[0] = 8'h5A; tx[1] = 8'hC3; tx[2] = 8'h01;
        seq[0] = 8'h00; seq[1] = 8'h80; seq[2] = 8'h00; seq_len = 3;
        run_op(1'b1, 24'h0002F0, 3, 100, 100, 4, 1'b0);
        ex_n = 0; ex_prog(24'h0002F0, 8'h5A); ex_prog(24'h0002F1, 8'hC3);
        ex_prog(24'h0002F2, 8'h01); ex_push(24'h0, 8'hF0);
        cmp_log("R2");
        chk("R5", got_rd == 3, "reads", got_rd, 3);
    endtask

    task automatic t_prog_recheck_ok;
        tx[0] = 8'h80;
        seq[0] = 8'h20; seq[1] = 8'hA0; seq_len = 2;
        run_op(1'b1, 24'h000400, 1, 100, 100, 0, 1'b0);
        chk("R6", got_err == 0, "err", got_err, 0);
        chk("R6", got_rd == 2, "reads", got_rd, 2);
        chk("R8", got_wr == 6, "writes", got_wr, 6);
    endtask

    task automatic t_prog_recheck_bad;
        tx[0] = 8'h80;
        seq[0] = 8'h20; seq[1] = 8'h20; seq_len = 2;
        run_op(1'b1, 24'h000500, 1, 100, 100, 0, 1'b0);
        chk("R6", got_err == 2, "err", got_err, 2);
        chk("R6", got_rd == 2, "reads", got_rd, 2);
        chk("R8", got_wr == 5, "writes", got_wr, 5);
    endtask

    task automatic t_prog_restart;
        tx[0] = 8'h80; tx[1] = 8'h80;
        seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h80;
        seq[3] = 8'h00; seq[4] = 8'h00; seq[5] = 8'h80; seq_len = 6;
        run_op(1'b1, 24'h000600, 2, 100, 3, 0, 1'b0);
        chk("R7", got_err == 0, "err with per-byte restart", got_err, 0);
        chk("R7", got_rd == 6, "reads", got_rd, 6);
    endtask

    task automatic t_prog_cycto;
        tx[0] = 8'h80;
        seq[0] = 8'h00; seq_len = 1;
        run_op(1'b1, 24'h000700, 1, 100, 4, 0, 1'b0);
        chk("R7", got_err == 1, "err", got_err, 1);
        chk("R7", got_rd == 4, "reads", got_rd, 4);
    endtask

    task automatic t_prog_len0;
        seq[0] = 8'h00; seq_len = 1;
        run_op(1'b1, 24'h000800, 0, 100, 100, 0, 1'b0);
        ex_n = 0; ex_push(24'h0, 8'hF0);
        cmp_log("R9");
        chk("R9", got_err == 0, "err", got_err, 0);
        chk("R9", got_rd == 0, "reads", got_rd, 0);
    endtask

    task automatic t_busy_ignore;
        seq[0] = 8'h40; seq[1] = 8'h40; seq_len = 2;
        run_op(1'b0, 24'h090000, 0, 100, 100, 0, 1'b1);
        ex_n = 0; ex_erase(24'h090000); ex_push(24'h0, 8'hF0);
        cmp_log("R10");
        chk("R10", got_err == 0, "err", got_err, 0);
        repeat (3) @(negedge clk);
        chk("R10", busy === 1'b0, "no late start", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_erase_quick();
        t_erase_toggle();
        t_erase_devto();
        t_erase_devto_clear();
        t_erase_cycto();
        t_coincide();
        t_prog_two();
        t_prog_gap();
        t_prog_recheck_ok();
        t_prog_recheck_bad();
        t_prog_restart();
        t_prog_cycto();
        t_prog_len0();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule